// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Engine

This block moves a run of items for one DMA channel. It reads its work order from a small descriptor store that holds two structures, a primary and an alternate. Each structure is four 32-bit words: the source end pointer, the destination end pointer, a control word, and one spare word. The end pointers give the last byte of each buffer. The engine works out the address of each item backwards from the end pointer and the number of items still to go. It copies each item with a read and then a write on a one-cycle synchronous memory port. When it pauses or finishes, it writes the updated control word back to the descriptor store.

The engine asks for the bus with `arb_req` and waits for `arb_gnt` before it fetches a descriptor. After every 2^R items it gives the bus up and asks for it again. Three cycle types run: basic, auto and ping-pong. A basic transfer only advances while the request is high. An auto transfer runs to the end once it has started. A ping-pong transfer moves on to the other structure each time one structure completes. At the end of a transfer the engine rewrites the cycle type as stop and clears the channel enable. A control word it cannot run raises an error and stops the channel before any memory access.

Top module: `dma_engine`

## Requirements
- R1: After reset, `chan_en`, `arb_req`, `xfer_done`, `cfg_err`, `mem_rd`, `mem_wr` and `cur_alt` are 0, and `rem_count` is 0.
- R2: After `arb_gnt`, the engine reads words 0, 1 and 2 of the selected structure. The descriptor address is {structure bit, word[1:0]}, and structure bit 1 means alternate. Word 0 is the source end pointer, word 1 the destination end pointer, and word 2 the control word. Control word fields: [31:30] destination increment, [29:28] destination size, [27:26] source increment, [25:24] source size, [17:14] arbitration exponent R, [13:4] item count minus one, [2:0] cycle type (0 stop, 1 basic, 2 auto, 3 ping-pong).
- R3: With n items remaining, an item's address is end − (n << inc) + 1. Increment codes 0, 1 and 2 step by 1, 2 and 4 bytes. Increment code 3 holds the address at the end pointer. Each item is read from the source and then written to the destination, with `mem_size` giving the size (0 = 8, 1 = 16, 2 = 32 bits). A write always follows a read.
- R4: After 2^R items since the grant, the engine writes the control word back, drops `arb_req` for at least one cycle, and arbitrates again before it continues.
- R5: At an arbitration boundary or a pause, the control word is written back to word 2 with bits [13:4] = remaining − 1 and all other bits unchanged.
- R6: On the last item, the control word is written back with [13:4] = 0 and [2:0] = 0. `xfer_done` then pulses for one cycle and `rem_count` reads 0. If the last item also closes an arbitration window, only the completion writeback happens and no further arbitration follows.
- R7: In basic mode, an item starts only while `chan_req` is high. If the request is low when an item would start, the count is written back and the bus is released. The transfer resumes at the right addresses when the request returns.
- R8: In auto mode, the transfer runs to completion without `chan_req` after it has started. Completion clears `chan_en`.
- R9: In ping-pong mode, completion toggles `cur_alt` and leaves `chan_en` set. The next request loads the other structure. A loaded cycle type of 0 clears `chan_en` without any memory access.
- R10: The following control words are illegal: cycle type 4 or above, a size of 3, source size different from destination size, a non-3 increment smaller than its size, or R above 10. An illegal control word sets `cfg_err`, clears `chan_en` and makes no memory access. `chan_en_set` clears `cfg_err`.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle, and either one is high only while `arb_req` is high.
- R12: `rem_count` drops by exactly one after each item written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en_set | input | 1 | Pulse: enable the channel, select primary, clear error |
| chan_req | input | 1 | Transfer request |
| arb_req | output | 1 | Bus request, held while the engine owns the bus |
| arb_gnt | input | 1 | Bus grant |
| desc_rd | output | 1 | Descriptor read strobe |
| desc_wr | output | 1 | Descriptor write strobe |
| desc_addr | output | 3 | Descriptor word address {structure, word} |
| desc_wdata | output | 32 | Control word written back |
| desc_rdata | input | 32 | Descriptor read data, one cycle after the strobe |
| mem_rd | output | 1 | Data read strobe |
| mem_wr | output | 1 | Data write strobe |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Item size code |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, one cycle after the strobe, right-aligned |
| chan_en | output | 1 | Channel enabled |
| xfer_done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Illegal control word seen |
| rem_count | output | 11 | Items still to transfer |
| cur_alt | output | 1 | Structure in use (1 = alternate) |

## Verification
Completion and the end of an arbitration window can fall on the same item. This happens whenever the item count is a multiple of 2^R. The bench sets this up with four byte items and R = 2. It then checks three things: the only writeback carries the stop type and a zero count, `xfer_done` pulses once, and `arb_req` rises exactly once over the whole transfer. A second run with six items and R = 1 shows the boundary on its own for comparison: three arbitrations, and a first writeback that keeps the auto type and a count field of 3.

// File: rtl/dmae_pkg.sv
// Package: shared constants, control-word field positions and types for the
// single-channel DMA engine. Assumes a fixed 32-bit control word.
package dmae_pkg;

    localparam int CTRL_W     = 32;
    localparam int CNT_FIELD  = 10;             // width of the count-minus-one field
    localparam int EXP_W      = 4;              // width of the arbitration exponent
    localparam int MAX_EXP    = CNT_FIELD;      // largest legal exponent
    localparam int DESC_AW    = 3;              // {structure, word[1:0]}

    localparam int F_DINC_LO  = 30;
    localparam int F_DSZ_LO   = 28;
    localparam int F_SINC_LO  = 26;
    localparam int F_SSZ_LO   = 24;
    localparam int F_EXP_LO   = 14;
    localparam int F_CNT_LO   = 4;
    localparam int F_BURST    = 3;

    localparam logic [1:0] INC_HOLD = 2'd3;

    typedef enum logic [2:0] {
        CYC_STOP  = 3'd0,
        CYC_BASIC = 3'd1,
        CYC_AUTO  = 3'd2,
        CYC_PPONG = 3'd3
    } cyc_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ARB, ST_LD0, ST_LD1, ST_LD2, ST_LD3,
        ST_CHK, ST_RD, ST_WR, ST_WB
    } eng_state_e;

endpackage

// File: rtl/dmae_ctrl_decode.sv
// Module: splits a control word into its fields and judges whether it is
// runnable. Pure combinational; assumes the caller handles the stop type.
module dmae_ctrl_decode
    import dmae_pkg::*;
(
    input  logic [CTRL_W-1:0]    ctrl,
    output logic [1:0]           dinc,
    output logic [1:0]           sinc,
    output logic [1:0]           isize,
    output logic [EXP_W-1:0]     arb_exp,
    output logic [CNT_FIELD-1:0] cnt_m1,
    output logic [2:0]           cyc,
    output logic                 is_stop,
    output logic                 legal
);
    logic [1:0] dsz;

    // Field extraction
    always_comb begin
        dinc    = ctrl[F_DINC_LO +: 2];
        dsz     = ctrl[F_DSZ_LO  +: 2];
        sinc    = ctrl[F_SINC_LO +: 2];
        isize   = ctrl[F_SSZ_LO  +: 2];
        arb_exp = ctrl[F_EXP_LO  +: EXP_W];
        cnt_m1  = ctrl[F_CNT_LO  +: CNT_FIELD];
        cyc     = ctrl[2:0];
    end

    // Legality: known cycle type, sane size, increments no smaller than size
    always_comb begin
        is_stop = (cyc == CYC_STOP);
        legal   = (cyc == CYC_BASIC || cyc == CYC_AUTO || cyc == CYC_PPONG)
                && (isize != 2'd3)
                && (isize == dsz)
                && (sinc == INC_HOLD || sinc >= isize)
                && (dinc == INC_HOLD || dinc >= dsz)
                && (arb_exp <= EXP_W'(MAX_EXP));
    end
endmodule

// File: rtl/dmae_addr_gen.sv
// Module: derives the current item address from an end pointer, the
// increment code and the remaining item count. Assumes remain >= 1 when used.
module dmae_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 11
) (
    input  logic [ADDR_W-1:0] end_ptr,
    input  logic [1:0]        inc,
    input  logic [CNT_W-1:0]  remain,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] span;

    // Address = end - (remain << inc) + 1, or end itself for a held address
    always_comb begin
        span = ADDR_W'(remain) << inc;
        addr = (inc == 2'd3) ? end_ptr : (end_ptr - span + ADDR_W'(1));
    end
endmodule

// File: rtl/dmae_arb_window.sv
// Module: counts items since the last grant and flags the item that closes
// a 2^exp window. Assumes exp has been checked legal before use.
module dmae_arb_window #(
    parameter int CNT_W = 11,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [EXP_W-1:0] arb_exp,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Window size and closing condition
    always_comb begin
        limit = CNT_W'(1) << arb_exp;
        last  = (cnt_q + CNT_W'(1)) == limit;
    end

    // Item counter, restarted at each grant
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (step)     cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/dma_engine.sv
// Module: single-channel DMA cycle engine. Fetches a descriptor (primary or
// alternate), copies items backwards-derived from end pointers, re-arbitrates
// every 2^R items and writes the control word back. Assumes one-cycle
// synchronous descriptor and data memories and a grant that stays high while
// arb_req is held.
module dma_engine
    import dmae_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en_set,
    input  logic              chan_req,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic              desc_rd,
    output logic              desc_wr,
    output logic [2:0]        desc_addr,
    output logic [31:0]       desc_wdata,
    input  logic [31:0]       desc_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              chan_en,
    output logic              xfer_done,
    output logic              cfg_err,
    output logic [10:0]       rem_count,
    output logic              cur_alt
);
    localparam int CNT_W = CNT_FIELD + 1;
    localparam int NPORT = 2;   // 0 = source, 1 = destination

    eng_state_e          state_q;
    logic [ADDR_W-1:0]   end_q [NPORT];
    logic [CTRL_W-1:0]   ctrl_q;
    logic [CNT_W-1:0]    rem_q;
    logic                en_q, err_q, done_q, alt_q, auto_q;

    logic [1:0]           dinc, sinc, isize;
    logic [EXP_W-1:0]     arb_exp;
    logic [CNT_FIELD-1:0] cnt_m1;
    logic [2:0]           cyc;
    logic                 is_stop, legal;
    logic [1:0]           inc_sel [NPORT];
    logic [ADDR_W-1:0]    addr_sel [NPORT];
    logic                 win_last, win_clr, win_step;
    logic                 gate_ok, final_wb;
    logic [CNT_W-1:0]     rem_m1;

    dmae_ctrl_decode u_dec (
        .ctrl    (ctrl_q),
        .dinc    (dinc),
        .sinc    (sinc),
        .isize   (isize),
        .arb_exp (arb_exp),
        .cnt_m1  (cnt_m1),
        .cyc     (cyc),
        .is_stop (is_stop),
        .legal   (legal)
    );

    assign inc_sel[0] = sinc;
    assign inc_sel[1] = dinc;

    // One address generator per side of the copy
    for (genvar g = 0; g < NPORT; g++) begin : g_addr
        dmae_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ag (
            .end_ptr (end_q[g]),
            .inc     (inc_sel[g]),
            .remain  (rem_q),
            .addr    (addr_sel[g])
        );
    end

    dmae_arb_window #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (win_clr),
        .step    (win_step),
        .arb_exp (arb_exp),
        .last    (win_last)
    );

    // Window control and request gating
    always_comb begin
        win_clr  = (state_q == ST_ARB) && arb_gnt;
        win_step = (state_q == ST_WR);
        gate_ok  = (cyc == CYC_AUTO) || chan_req;
        final_wb = (rem_q == '0);
        rem_m1   = rem_q - CNT_W'(1);
    end

    // Bus, descriptor and data port outputs
    always_comb begin
        arb_req   = (state_q != ST_IDLE);
        desc_rd   = (state_q == ST_LD0) || (state_q == ST_LD1) || (state_q == ST_LD2);
        desc_wr   = (state_q == ST_WB);
        unique case (state_q)
            ST_LD0:  desc_addr = {alt_q, 2'd0};
            ST_LD1:  desc_addr = {alt_q, 2'd1};
            default: desc_addr = {alt_q, 2'd2};
        endcase
        if (final_wb)
            desc_wdata = {ctrl_q[31:F_EXP_LO], {CNT_FIELD{1'b0}}, ctrl_q[F_BURST], 3'b000};
        else
            desc_wdata = {ctrl_q[31:F_EXP_LO], rem_m1[CNT_FIELD-1:0], ctrl_q[3:0]};
        mem_rd    = (state_q == ST_RD) && gate_ok;
        mem_wr    = (state_q == ST_WR);
        mem_addr  = (state_q == ST_WR) ? addr_sel[1] : addr_sel[0];
        mem_size  = isize;
        mem_wdata = mem_rdata;
    end

    // Sequencer: arbitration, descriptor load, item copy, writeback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            end_q[0] <= '0;
            end_q[1] <= '0;
            ctrl_q  <= '0;
            rem_q   <= '0;
            en_q    <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            alt_q   <= 1'b0;
            auto_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (en_q && (chan_req || auto_q)) state_q <= ST_ARB;
                ST_ARB:  if (arb_gnt) state_q <= ST_LD0;
                ST_LD0:  state_q <= ST_LD1;
                ST_LD1:  begin end_q[0] <= desc_rdata; state_q <= ST_LD2; end
                ST_LD2:  begin end_q[1] <= desc_rdata; state_q <= ST_LD3; end
                ST_LD3:  begin ctrl_q <= desc_rdata;   state_q <= ST_CHK; end
                ST_CHK: begin
                    state_q <= ST_IDLE;
                    if (is_stop) begin
                        en_q   <= 1'b0;
                        auto_q <= 1'b0;
                    end else if (!legal) begin
                        err_q  <= 1'b1;
                        en_q   <= 1'b0;
                        auto_q <= 1'b0;
                    end else begin
                        rem_q   <= CNT_W'(cnt_m1) + CNT_W'(1);
                        auto_q  <= (cyc == CYC_AUTO);
                        state_q <= ST_RD;
                    end
                end
                ST_RD:   state_q <= gate_ok ? ST_WR : ST_WB;
                ST_WR: begin
                    rem_q   <= rem_m1;
                    state_q <= (rem_q == CNT_W'(1) || win_last) ? ST_WB : ST_RD;
                end
                ST_WB: begin
                    state_q <= ST_IDLE;
                    if (final_wb) begin
                        done_q <= 1'b1;
                        auto_q <= 1'b0;
                        if (cyc == CYC_PPONG) alt_q <= ~alt_q;
                        else                  en_q  <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (chan_en_set) begin
                en_q   <= 1'b1;
                err_q  <= 1'b0;
                alt_q  <= 1'b0;
                auto_q <= 1'b0;
            end
        end
    end

    // Status outputs
    always_comb begin
        chan_en   = en_q;
        xfer_done = done_q;
        cfg_err   = err_q;
        rem_count = rem_q;
        cur_alt   = alt_q;
    end
endmodule

// File: rtl/dmae_checker.sv
// Module: protocol checker for dma_engine, attached by bind. Observes ports
// only; assumes synchronous active-low reset.
module dmae_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        arb_req,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        chan_en,
    input logic        xfer_done,
    input logic        cfg_err,
    input logic [10:0] rem_count
);
    // R11: read and write strobes never overlap
    a_r11_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11: data accesses only while the bus is held
    a_r11_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> arb_req);

    // R3: every write is preceded by a read
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    // R12: one item written, one count removed
    a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> rem_count == $past(rem_count) - 11'd1);

    // R6: completion shows an empty count and lasts one cycle
    a_r6_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> rem_count == 11'd0);
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R10: an error stops the channel
    a_r10_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> !chan_en);
endmodule

bind dma_engine dmae_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_req   (arb_req),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .chan_en   (chan_en),
    .xfer_done (xfer_done),
    .cfg_err   (cfg_err),
    .rem_count (rem_count)
);

// File: tb/dma_engine_tb.sv
// Bench: scoreboard of expected item writes, pushed by the setup task and
// popped by a monitor as the engine writes memory. 125 MHz clock.
module dma_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en_set = 1'b0;
    logic        chan_req = 1'b0;
    logic        arb_req, arb_gnt = 1'b0;
    logic        desc_rd, desc_wr;
    logic [2:0]  desc_addr;
    logic [31:0] desc_wdata, desc_rdata = '0;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [1:0]  mem_size;
    logic        chan_en, xfer_done, cfg_err, cur_alt;
    logic [10:0] rem_count;

    logic [31:0] dmem [8];
    logic        tb_dwr = 1'b0;
    logic [2:0]  tb_daddr = '0;
    logic [31:0] tb_ddata = '0;

    logic [65:0] exp_q [$];
    int n_chk = 0, n_fail = 0;
    int wr_seen = 0, rd_seen = 0, done_seen = 0, arb_rises = 0, wb_n = 0;
    logic [31:0] wb_first = '0;
    logic arb_prev = 1'b0;

    always #4 clk = ~clk;

    dma_engine u_dut (.*);

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] * 8'd7 + 8'd3;
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a, input logic [1:0] sz);
        case (sz)
            2'd0:    return {24'd0, pat(a)};
            2'd1:    return {16'd0, pat(a + 1), pat(a)};
            default: return {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
        endcase
    endfunction

    function automatic logic [31:0] mk(input int dinc, input int dsz, input int sinc,
                                       input int ssz, input int r, input int cnt, input int typ);
        logic [9:0] c = 10'(cnt - 1);
        return {2'(dinc), 2'(dsz), 2'(sinc), 2'(ssz), 6'd0, 4'(r), c, 1'b0, 3'(typ)};
    endfunction

    task automatic chk(input string req, input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory models: one-cycle descriptor store and pattern-backed data read
    always @(posedge clk) begin
        if (desc_rd) desc_rdata <= dmem[desc_addr];
        if (desc_wr) dmem[desc_addr] <= desc_wdata;
        else if (tb_dwr) dmem[tb_daddr] <= tb_ddata;
        if (mem_rd) mem_rdata <= rd_word(mem_addr, mem_size);
        arb_gnt <= arb_req;
    end

    // Monitor: scoreboard pop on every write, event counters
    always @(negedge clk) begin
        if (mem_wr) begin
            wr_seen++;
            if (exp_q.size() == 0) chk("R3 unexpected write", {mem_addr, mem_size, mem_wdata}, '0);
            else chk("R3 item write", {mem_addr, mem_size, mem_wdata}, exp_q.pop_front());
        end
        if (mem_rd) rd_seen++;
        if (xfer_done) done_seen++;
        if (arb_req && !arb_prev) arb_rises++;
        arb_prev = arb_req;
        if (desc_wr) begin
            if (wb_n == 0) wb_first = desc_wdata;
            wb_n++;
        end
    end

    task automatic dput(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_dwr = 1'b1; tb_daddr = a; tb_ddata = d;
        @(negedge clk);
        tb_dwr = 1'b0;
    endtask

    // Driver: writes a descriptor and pushes the expected item writes
    task automatic setup(input logic alt, input logic [31:0] s0, input logic [31:0] d0,
                         input int sinc, input int dinc, input int sz, input int cnt,
                         input int r, input int typ);
        logic [31:0] se = (sinc == 3) ? s0 : s0 + (cnt << sinc) - 1;
        logic [31:0] de = (dinc == 3) ? d0 : d0 + (cnt << dinc) - 1;
        dput({alt, 2'd0}, se);
        dput({alt, 2'd1}, de);
        dput({alt, 2'd2}, mk(dinc, sz, sinc, sz, r, cnt, typ));
        for (int k = 0; k < cnt; k++) begin
            logic [31:0] sa = (sinc == 3) ? s0 : s0 + (k << sinc);
            logic [31:0] da = (dinc == 3) ? d0 : d0 + (k << dinc);
            exp_q.push_back({da, 2'(sz), rd_word(sa, 2'(sz))});
        end
    endtask

    task automatic clear_counts();
        done_seen = 0; arb_rises = 0; wb_n = 0; wr_seen = 0; rd_seen = 0;
    endtask

    task automatic enable();
        @(negedge clk); chan_en_set = 1'b1;
        @(negedge clk); chan_en_set = 1'b0;
    endtask

    task automatic wait_off();
        do @(negedge clk); while (chan_en);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 chan_en", chan_en, 0);
        chk("R1 arb_req", arb_req, 0);
        chk("R1 done/err", {xfer_done, cfg_err}, 0);
        chk("R1 strobes", {mem_rd, mem_wr, desc_wr}, 0);
        chk("R1 rem_count/alt", {rem_count, cur_alt}, 0);

        // R6 with R2: basic, 4 bytes, window 4 coincides with completion
        setup(1'b0, 32'h10, 32'h80, 0, 0, 0, 4, 2, 1);
        clear_counts(); chan_req = 1'b1; enable(); wait_off(); chan_req = 1'b0;
        chk("R3 all items", exp_q.size(), 0);
        chk("R6 done once", done_seen, 1);
        chk("R6 single arbitration", arb_rises, 1);
        chk("R6 stop writeback", dmem[2], mk(0, 0, 0, 0, 2, 1, 0));
        chk("R6 rem zero", rem_count, 0);

        // R4/R5/R8: auto, halfwords, 6 items, window 2, one-cycle request
        setup(1'b0, 32'h20, 32'h90, 1, 1, 1, 6, 1, 2);
        clear_counts(); enable();
        @(negedge clk); chan_req = 1'b1; @(negedge clk); chan_req = 1'b0;
        wait_off();
        chk("R8 auto completes", exp_q.size(), 0);
        chk("R4 three arbitrations", arb_rises, 3);
        chk("R5 first writeback", wb_first, mk(1, 1, 1, 1, 1, 4, 2));
        chk("R8 enable cleared", chan_en, 0);

        // R3: held source address, words, window 1024
        setup(1'b0, 32'h40, 32'hA0, 3, 2, 2, 3, 10, 2);
        clear_counts(); enable();
        @(negedge clk); chan_req = 1'b1; @(negedge clk); chan_req = 1'b0;
        wait_off();
        chk("R3 held source items", exp_q.size(), 0);
        chk("R3 write count", wr_seen, 3);

        // R10: word size with byte increment is illegal
        dput(3'd0, 32'h40); dput(3'd1, 32'hA0);
        dput(3'd2, mk(2, 2, 0, 2, 0, 2, 2));
        clear_counts(); enable();
        @(negedge clk); chan_req = 1'b1; @(negedge clk); chan_req = 1'b0;
        repeat (15) @(negedge clk);
        chk("R10 err set", cfg_err, 1);
        chk("R10 channel stopped", chan_en, 0);
        chk("R10 no access", rd_seen + wr_seen, 0);
        dput(3'd2, mk(0, 0, 0, 0, 0, 2, 5));
        enable(); @(negedge clk);
        chk("R10 err cleared by enable", {cfg_err, chan_en}, 2'b01);
        chan_req = 1'b1; @(negedge clk); chan_req = 1'b0;
        repeat (15) @(negedge clk);
        chk("R10 scatter type rejected", {cfg_err, chan_en}, 2'b10);
        chk("R10 no access type 5", rd_seen + wr_seen, 0);

        // R7: basic pause after two items, then resume
        setup(1'b0, 32'h50, 32'hB0, 0, 0, 0, 5, 10, 1);
        clear_counts(); chan_req = 1'b1; enable();
        begin
            int n = 0;
            while (n < 2) begin @(negedge clk); if (mem_wr) n++; end
        end
        chan_req = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 paused writes", wr_seen, 2);
        chk("R12 remaining count", rem_count, 3);
        chk("R5 pause writeback", dmem[2], mk(0, 0, 0, 0, 10, 3, 1));
        chk("R7 bus released", {arb_req, chan_en}, 2'b01);
        chan_req = 1'b1; wait_off(); chan_req = 1'b0;
        chk("R7 resumed items", exp_q.size(), 0);

        // R9: ping-pong primary then alternate, primary then reads stop
        setup(1'b0, 32'h60, 32'hC0, 0, 0, 0, 2, 10, 3);
        setup(1'b1, 32'h68, 32'hD0, 0, 0, 0, 3, 10, 3);
        clear_counts(); chan_req = 1'b1; enable(); wait_off(); chan_req = 1'b0;
        chk("R9 both structures copied", exp_q.size(), 0);
        chk("R9 two completions", done_seen, 2);
        chk("R9 back on primary", cur_alt, 0);
        chk("R9 alternate stopped", dmem[6], mk(0, 0, 0, 0, 10, 1, 0));
        chk("R9 channel off", chan_en, 0);

        summary();
    end
endmodule